// File: doc/BRIEF.md
# Double-Buffered Peripheral DMA Channel

This block is one DMA channel that streams data between a fixed peripheral FIFO address and two memory buffers used in alternation. Software fills in a start address and a transfer count for each buffer, enables one or both, and sets the run bit. The channel then works through the buffer named by its active-buffer flag. When that buffer is exhausted, the channel marks it done, withdraws its enable and turns to the other buffer. Software can refill a finished buffer while the channel drains its partner, so the stream never has to stop.

Every transfer has two phases: a read from the source port, then a write of the same word to the destination port. Both ports are plain request/acknowledge interfaces. The control word is changed through two offsets, one that sets bits and one that clears them. This lets software and the channel's own updates share the register without read-modify-write races. A status bit tells software when the channel has really stopped after the run bit is withdrawn.

The sequencer has four states. ST_HALT is stopped, with the status bit high. ST_CHECK is armed and waiting on or judging the active buffer. ST_READ asks the source for a word, and ST_WRITE hands that word to the destination. The transitions are:
- ST_HALT→ST_CHECK when run is set.
- ST_CHECK→ST_HALT when run is clear.
- ST_CHECK→ST_READ when the active buffer is enabled with a nonzero count.
- ST_CHECK stays in ST_CHECK while it completes a zero-count buffer or waits for an enable.
- ST_READ→ST_WRITE on the source acknowledge.
- ST_WRITE→ST_CHECK on the destination acknowledge.

Top module: `pingpong_dma_chan`

## Requirements
- R1: After reset, the control word reads 0x40 (only the stopped bit is high). Every other register reads zero, irq is low and neither port requests.
- R2: A write to offset 0x00 ORs the written ones into the control word, and a write to 0x04 clears the bits written as ones. Bit 6 is read-only and shows the stopped state. Bit 14 and bits 31:24 always read zero, and offset 0x04 reads zero.
- R3: Offset 0x08 holds the peripheral address. Offsets 0x0C/0x10 hold buffer 0's start and count, and 0x14/0x18 hold buffer 1's. A count word carries the count in bits 15:0 and four high address bits in 19:16. Writes whose address bits 1:0 are not zero are ignored.
- R4: Each transfer reads one word from the source and writes it unchanged to the destination. Control bit 12 set to 0 moves memory to peripheral, and set to 1 moves peripheral to memory. The direction is sampled when each transfer starts.
- R5: The memory address is the active buffer's high bits joined to its start register. The start register advances by 1, 2 or 4 per transfer when control bits 10:9 are 0, 1 or 2 (3 acts as 4). The peripheral address is control bits 23:20 joined to the peripheral register and never moves.
- R6: The active buffer's count drops by one at each completed transfer and can be read while it changes.
- R7: An enabled active buffer with a count of zero is completed at once. Its done bit is set (bit 1 or bit 3), its enable is cleared (bit 0 or bit 2) and the active flag (bit 4) flips. A buffer programmed with zero completes without any transfer.
- R8: If the active buffer is not enabled while run (bit 5) is set, the channel makes no requests and keeps bit 6 low. It starts as soon as that enable is set.
- R9: Clearing run lets any transfer in progress finish. Bit 6 then goes high and stays high while run is clear.
- R10: irq is high exactly while bit 7 is set and at least one done bit is set. Clearing the done bits drops it.
- R11: A request stays asserted, with unchanged address and write flag, until its acknowledge arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 36 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory acknowledge |
| per_req | output | 1 | Peripheral request |
| per_we | output | 1 | Peripheral request is a write |
| per_addr | output | 36 | Peripheral FIFO address |
| per_wdata | output | 32 | Peripheral write data |
| per_rdata | input | 32 | Peripheral read data, valid with per_ack |
| per_ack | input | 1 | Peripheral acknowledge |
| irq | output | 1 | Buffer-done interrupt |

## Verification
A wrong active flag or enable shows up at the ports within one transfer. The next memory address comes from the wrong buffer, or a done bit appears when the control word is read. A count that decrements wrongly shows in the live count read and in the number of logged peripheral or memory writes once a buffer completes. A sequencer that reaches the stopped state early or late is caught by comparing the residue read after the stopped bit rises against the transfers already logged. A wrongly staged data word shows at the destination port on the very transfer it corrupts.

// File: rtl/ppd_pkg.sv
package ppd_pkg;

    typedef enum logic [1:0] {
        ST_HALT  = 2'd0,
        ST_CHECK = 2'd1,
        ST_READ  = 2'd2,
        ST_WRITE = 2'd3
    } xfer_state_e;

    // word index of each register (byte offset >> 2)
    localparam int IDX_CTRL_SET = 0;
    localparam int IDX_CTRL_CLR = 1;
    localparam int IDX_PADDR    = 2;
    localparam int IDX_B0_START = 3;   // buffer b start at 3 + 2b, count at 4 + 2b

    // control word bit positions
    localparam int B_EN0   = 0;
    localparam int B_DONE0 = 1;
    localparam int B_EN1   = 2;
    localparam int B_DONE1 = 3;
    localparam int B_ACT   = 4;
    localparam int B_RUN   = 5;
    localparam int B_STOP  = 6;
    localparam int B_IE    = 7;
    localparam int B_WID   = 9;
    localparam int B_DIR   = 12;
    localparam int B_PHI   = 20;

    localparam logic [31:0] CTRL_WMASK = 32'h00FF_BFBF;

endpackage

// File: rtl/ppd_regfile.sv
module ppd_regfile
    import ppd_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int HI_W  = 4,
    localparam int ADDR_W = 32 + HI_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [4:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              stopped_i,
    input  logic              step_i,
    input  logic              buf_done_i,
    output logic              run_o,
    output logic              dir_o,
    output logic              en_act_o,
    output logic              cnt_zero_o,
    output logic              irq_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [ADDR_W-1:0] per_addr_o
);

    logic [31:0] ctrl_q, ctrl_d, paddr_q, stride;
    logic [2:0]  word_idx;
    logic        wr_ok, wr_set, wr_clr, act;
    logic [1:0][31:0]       start_v;
    logic [1:0][CNT_W-1:0]  cnt_v;
    logic [1:0][HI_W-1:0]   hi_v;
    logic [1:0][31:0]       cnt_word;
    logic [CNT_W-1:0]       cnt_act;

    assign word_idx = reg_addr[4:2];
    assign wr_ok    = reg_wr && (reg_addr[1:0] == 2'b00);
    assign wr_set   = wr_ok && (word_idx == 3'(IDX_CTRL_SET));
    assign wr_clr   = wr_ok && (word_idx == 3'(IDX_CTRL_CLR));
    assign act      = ctrl_q[B_ACT];

    always_comb begin
        case (ctrl_q[B_WID +: 2])
            2'd0:    stride = 32'd1;
            2'd1:    stride = 32'd2;
            default: stride = 32'd4;
        endcase
    end

    // hardware completion first, then software set/clear on top
    always_comb begin
        ctrl_d = ctrl_q;
        if (buf_done_i) begin
            ctrl_d[act ? B_DONE1 : B_DONE0] = 1'b1;
            ctrl_d[act ? B_EN1 : B_EN0]     = 1'b0;
            ctrl_d[B_ACT]                   = ~act;
        end
        if (wr_set) ctrl_d = ctrl_d | (reg_wdata & CTRL_WMASK);
        if (wr_clr) ctrl_d = ctrl_d & ~(reg_wdata & CTRL_WMASK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            paddr_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            if (wr_ok && word_idx == 3'(IDX_PADDR)) paddr_q <= reg_wdata;
        end
    end

    for (genvar b = 0; b < 2; b++) begin : g_buf
        logic [31:0]      start_r;
        logic [CNT_W-1:0] cnt_r;
        logic [HI_W-1:0]  hi_r;
        logic             wr_start, wr_cnt, hit;

        assign wr_start = wr_ok && (word_idx == 3'(IDX_B0_START + 2 * b));
        assign wr_cnt   = wr_ok && (word_idx == 3'(IDX_B0_START + 2 * b + 1));
        assign hit      = step_i && (act == 1'(b));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                start_r <= '0;
                cnt_r   <= '0;
                hi_r    <= '0;
            end else begin
                if (wr_start)  start_r <= reg_wdata;
                else if (hit)  start_r <= start_r + stride;
                if (wr_cnt) begin
                    cnt_r <= reg_wdata[CNT_W-1:0];
                    hi_r  <= reg_wdata[CNT_W +: HI_W];
                end else if (hit) begin
                    cnt_r <= cnt_r - 1'b1;
                end
            end
        end

        assign start_v[b]  = start_r;
        assign cnt_v[b]    = cnt_r;
        assign hi_v[b]     = hi_r;
        assign cnt_word[b] = 32'({hi_r, cnt_r});
    end

    always_comb begin
        case (word_idx)
            3'd0:    reg_rdata = ctrl_q | (32'(stopped_i) << B_STOP);
            3'd2:    reg_rdata = paddr_q;
            3'd3:    reg_rdata = start_v[0];
            3'd4:    reg_rdata = cnt_word[0];
            3'd5:    reg_rdata = start_v[1];
            3'd6:    reg_rdata = cnt_word[1];
            default: reg_rdata = '0;
        endcase
    end

    assign cnt_act    = cnt_v[act];
    assign run_o      = ctrl_q[B_RUN];
    assign dir_o      = ctrl_q[B_DIR];
    assign en_act_o   = act ? ctrl_q[B_EN1] : ctrl_q[B_EN0];
    assign cnt_zero_o = (cnt_act == '0);
    assign irq_o      = ctrl_q[B_IE] && (ctrl_q[B_DONE0] || ctrl_q[B_DONE1]);
    assign mem_addr_o = {hi_v[act], start_v[act]};
    assign per_addr_o = {ctrl_q[B_PHI +: HI_W], paddr_q};

    assert_step_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |-> (cnt_act != '0));

    assert_count_dec_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !reg_wr) |=> (cnt_act == $past(cnt_act) - 1'b1));

    assert_switch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_done_i && !reg_wr) |=> (ctrl_q[B_ACT] != $past(ctrl_q[B_ACT])));

    assert_done_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_done_i && !reg_wr && !act) |=> (ctrl_q[B_DONE0] && !ctrl_q[B_EN0]));

endmodule

// File: rtl/ppd_xfer_fsm.sv
module ppd_xfer_fsm
    import ppd_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              dir_i,
    input  logic              en_act_i,
    input  logic              cnt_zero_i,
    input  logic [ADDR_W-1:0] mem_addr_i,
    input  logic [ADDR_W-1:0] per_addr_i,
    output logic              stopped_o,
    output logic              step_o,
    output logic              buf_done_o,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              per_req,
    output logic              per_we,
    output logic [ADDR_W-1:0] per_addr,
    output logic [DATA_W-1:0] per_wdata,
    input  logic [DATA_W-1:0] per_rdata,
    input  logic              per_ack
);

    xfer_state_e state_q, state_d;
    logic [DATA_W-1:0] data_q;
    logic dir_q, src_ack, dst_ack;

    assign src_ack = dir_q ? per_ack : mem_ack;
    assign dst_ack = dir_q ? mem_ack : per_ack;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT:  if (run_i) state_d = ST_CHECK;
            ST_CHECK: begin
                if (!run_i)                        state_d = ST_HALT;
                else if (en_act_i && !cnt_zero_i)  state_d = ST_READ;
            end
            ST_READ:  if (src_ack) state_d = ST_WRITE;
            ST_WRITE: if (dst_ack) state_d = ST_CHECK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
            data_q  <= '0;
            dir_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_CHECK && state_d == ST_READ) dir_q <= dir_i;
            if (state_q == ST_READ && src_ack) data_q <= dir_q ? per_rdata : mem_rdata;
        end
    end

    always_comb begin
        stopped_o  = 1'b0;
        step_o     = 1'b0;
        buf_done_o = 1'b0;
        mem_req    = 1'b0;
        per_req    = 1'b0;
        mem_we     = 1'b0;
        per_we     = 1'b0;
        unique case (state_q)
            ST_HALT:  stopped_o = 1'b1;
            ST_CHECK: buf_done_o = run_i && en_act_i && cnt_zero_i;
            ST_READ: begin
                mem_req = !dir_q;
                per_req = dir_q;
            end
            ST_WRITE: begin
                mem_req = dir_q;
                per_req = !dir_q;
                mem_we  = 1'b1;
                per_we  = 1'b1;
                step_o  = dst_ack;
            end
        endcase
    end

    assign mem_addr  = mem_addr_i;
    assign per_addr  = per_addr_i;
    assign mem_wdata = data_q;
    assign per_wdata = data_q;

    assert_stop_after_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stopped_o) |-> !$past(run_i));

    assert_mem_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_wdata)));

    assert_per_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (per_req && !per_ack) |=> (per_req && $stable(per_we) && $stable(per_addr)));

endmodule

// File: rtl/pingpong_dma_chan.sv
module pingpong_dma_chan #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    parameter int HI_W   = 4,
    localparam int ADDR_W = 32 + HI_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [4:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              per_req,
    output logic              per_we,
    output logic [ADDR_W-1:0] per_addr,
    output logic [DATA_W-1:0] per_wdata,
    input  logic [DATA_W-1:0] per_rdata,
    input  logic              per_ack,
    output logic              irq
);

    logic stopped, step, buf_done, run, dir, en_act, cnt_zero;
    logic [ADDR_W-1:0] mem_addr_w, per_addr_w;

    ppd_regfile #(.CNT_W(CNT_W), .HI_W(HI_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .stopped_i(stopped), .step_i(step), .buf_done_i(buf_done),
        .run_o(run), .dir_o(dir), .en_act_o(en_act), .cnt_zero_o(cnt_zero), .irq_o(irq),
        .mem_addr_o(mem_addr_w), .per_addr_o(per_addr_w)
    );

    ppd_xfer_fsm #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .run_i(run), .dir_i(dir), .en_act_i(en_act), .cnt_zero_i(cnt_zero),
        .mem_addr_i(mem_addr_w), .per_addr_i(per_addr_w),
        .stopped_o(stopped), .step_o(step), .buf_done_o(buf_done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .per_req(per_req), .per_we(per_we), .per_addr(per_addr), .per_wdata(per_wdata),
        .per_rdata(per_rdata), .per_ack(per_ack)
    );

endmodule

// File: tb/sim_pingpong_dma_chan.sv
module sim_pingpong_dma_chan;

    localparam int AW = 36;
    localparam logic [31:0] EN0 = 32'h1, DN0 = 32'h2, EN1 = 32'h4, DN1 = 32'h8;
    localparam logic [31:0] ACT = 32'h10, RUN = 32'h20, STP = 32'h40, IE = 32'h80;

    logic clk = 1'b0, rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          reg_wr = 1'b0;
    logic [4:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          mem_req, mem_we, per_req, per_we, irq;
    logic [AW-1:0] mem_addr, per_addr;
    logic [31:0]   mem_wdata, per_wdata;
    logic [31:0]   mem_rdata = '0, per_rdata = '0;
    logic          mem_ack = 1'b0, per_ack = 1'b0;

    pingpong_dma_chan u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .per_req(per_req), .per_we(per_we), .per_addr(per_addr), .per_wdata(per_wdata),
        .per_rdata(per_rdata), .per_ack(per_ack), .irq(irq)
    );

    int n_chk = 0, n_fail = 0, finished = 0;
    int mcnt = 0, pcnt = 0, per_ctr = 0, mwait = 0, pwait = 0;
    logic [AW-1:0] mlog_addr [64];
    logic [31:0]   mlog_data [64];
    logic [AW-1:0] plog_addr [64];
    logic [31:0]   plog_data [64];
    logic mpend = 1'b0, ppend = 1'b0, mpend_we, ppend_we;
    logic [AW-1:0] mpend_addr, ppend_addr;

    function automatic logic [31:0] memval(input logic [AW-1:0] a);
        return {a[15:0] ^ 16'h3C3C, a[31:16] + 16'h0101};
    endfunction

    function automatic logic [31:0] stride_of(input logic [1:0] w);
        return (w == 2'd0) ? 32'd1 : (w == 2'd1) ? 32'd2 : 32'd4;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    // memory responder
    always @(negedge clk) begin
        if (mpend) begin
            n_chk++;
            if (!(mem_req && mem_addr == mpend_addr && mem_we == mpend_we)) begin
                n_fail++;
                $display("FAIL R11 memory request changed: got req=%0b addr=%0h expected req=1 addr=%0h",
                         mem_req, mem_addr, mpend_addr);
            end
        end
        mpend = 1'b0;
        if (mem_ack) mem_ack = 1'b0;
        else if (mem_req) begin
            if (mwait > 0) begin
                mwait--; mpend = 1'b1; mpend_addr = mem_addr; mpend_we = mem_we;
            end else begin
                mem_ack = 1'b1;
                if (mem_we) begin
                    if (mcnt < 64) begin mlog_addr[mcnt] = mem_addr; mlog_data[mcnt] = mem_wdata; end
                    mcnt++;
                end else mem_rdata = memval(mem_addr);
                mwait = $urandom_range(0, 3);
            end
        end
    end

    // peripheral responder
    always @(negedge clk) begin
        if (ppend) begin
            n_chk++;
            if (!(per_req && per_addr == ppend_addr && per_we == ppend_we)) begin
                n_fail++;
                $display("FAIL R11 peripheral request changed: got req=%0b addr=%0h expected req=1 addr=%0h",
                         per_req, per_addr, ppend_addr);
            end
        end
        ppend = 1'b0;
        if (per_ack) per_ack = 1'b0;
        else if (per_req) begin
            if (pwait > 0) begin
                pwait--; ppend = 1'b1; ppend_addr = per_addr; ppend_we = per_we;
            end else begin
                per_ack = 1'b1;
                if (per_we) begin
                    if (pcnt < 64) begin plog_addr[pcnt] = per_addr; plog_data[pcnt] = per_wdata; end
                    pcnt++;
                end else begin
                    per_rdata = 32'hA500_0000 + 32'(per_ctr);
                    per_ctr++;
                end
                pwait = $urandom_range(0, 3);
            end
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_ctrl(input logic [31:0] mask, output bit ok);
        logic [31:0] m;
        ok = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            rd(5'h00, m);
            if ((m & mask) == mask) begin ok = 1'b1; break; end
        end
    endtask

    task automatic stop_and_clean(input string req);
        bit ok;
        wr(5'h04, RUN);
        wait_ctrl(STP, ok);
        check(req, "stopped bit after run cleared", 64'(ok), 64'd1);
        wr(5'h04, 32'hFFFF_FFFF);
        repeat (4) @(negedge clk);
        mcnt = 0; pcnt = 0;
    endtask

    task automatic no_req_window(input string req, input int cycles);
        int seen = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (mem_req || per_req) seen++;
        end
        check(req, "requests while waiting", 64'(seen), 64'd0);
    endtask

    task automatic run_case(input bit dir, input logic [1:0] wid, input int c0, input int c1,
                            input logic [31:0] s0, input logic [31:0] s1,
                            input logic [3:0] h0, input logic [3:0] h1,
                            input logic [3:0] phi, input logic [31:0] pa, input bit ie);
        logic [31:0] m, st, sb;
        logic [AW-1:0] ea;
        bit ok, b;
        int k, pc0;
        pc0 = per_ctr;
        st = stride_of(wid);
        wr(5'h08, pa);
        wr(5'h0C, s0);
        wr(5'h10, {12'd0, h0, 16'(c0)});
        wr(5'h14, s1);
        wr(5'h18, {12'd0, h1, 16'(c1)});
        wr(5'h00, (32'(phi) << 20) | (32'(dir) << 12) | (32'(wid) << 9) | (ie ? IE : 32'd0) | EN0 | EN1);
        wr(5'h00, RUN);
        wait_ctrl(DN0 | DN1, ok);
        check("R7", "both buffers completed", 64'(ok), 64'd1);
        rd(5'h00, m);
        check("R7", "done set, enables cleared, active back to 0", 64'(m & 32'h1F), 64'(DN0 | DN1));
        check("R8", "stopped bit while armed", 64'(m & STP), 64'd0);
        check("R10", "irq with both done", 64'(irq), 64'(ie));
        rd(5'h10, m);
        check("R6", "buffer 0 residue", 64'(m), 64'({12'd0, h0, 16'd0}));
        rd(5'h18, m);
        check("R6", "buffer 1 residue", 64'(m), 64'({12'd0, h1, 16'd0}));
        rd(5'h0C, m);
        check("R5", "buffer 0 start advanced", 64'(m), 64'(s0 + 32'(c0) * st));
        rd(5'h14, m);
        check("R5", "buffer 1 start advanced", 64'(m), 64'(s1 + 32'(c1) * st));
        check("R4", "destination write count", 64'(dir ? mcnt : pcnt), 64'(c0 + c1));
        check("R4", "nothing written to the source", 64'(dir ? pcnt : mcnt), 64'd0);
        for (int i = 0; i < c0 + c1 && i < 64; i++) begin
            b = (i >= c0);
            k = b ? i - c0 : i;
            sb = b ? s1 : s0;
            ea = {(b ? h1 : h0), sb + 32'(k) * st};
            if (!dir) begin
                check("R5", "peripheral address", 64'(plog_addr[i]), 64'({phi, pa}));
                check("R4", "memory word to peripheral", 64'(plog_data[i]), 64'(memval(ea)));
            end else begin
                check("R5", "memory write address", 64'(mlog_addr[i]), 64'(ea));
                check("R4", "peripheral word to memory", 64'(mlog_data[i]),
                      64'(32'hA500_0000 + 32'(pc0 + i)));
            end
        end
        wr(5'h04, DN0);
        check("R10", "irq with only done1 left", 64'(irq), 64'(ie));
        wr(5'h04, DN1);
        check("R10", "irq after both done cleared", 64'(irq), 64'd0);
        stop_and_clean("R9");
    endtask

    initial begin
        logic [31:0] m;
        bit ok;
        int n;
        void'($urandom(32'd20251));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(5'h00, m); check("R1", "control after reset", 64'(m), 64'h40);
        rd(5'h08, m); check("R1", "peripheral address after reset", 64'(m), 64'd0);
        rd(5'h0C, m); check("R1", "start0 after reset", 64'(m), 64'd0);
        rd(5'h10, m); check("R1", "count0 after reset", 64'(m), 64'd0);
        rd(5'h14, m); check("R1", "start1 after reset", 64'(m), 64'd0);
        rd(5'h18, m); check("R1", "count1 after reset", 64'(m), 64'd0);
        check("R1", "irq after reset", 64'(irq), 64'd0);
        check("R1", "requests after reset", 64'({mem_req, per_req}), 64'd0);

        // R2: set/clear semantics, read-only and reserved bits
        wr(5'h00, 32'hFF70_4040);
        rd(5'h00, m); check("R2", "set offset ORs writable bits", 64'(m), 64'h0070_0040);
        wr(5'h00, 32'h0080_0000);
        rd(5'h00, m); check("R2", "second set keeps earlier bits", 64'(m), 64'h00F0_0040);
        wr(5'h04, 32'h0030_0000);
        rd(5'h00, m); check("R2", "clear offset clears written ones", 64'(m), 64'h00C0_0040);
        rd(5'h04, m); check("R2", "clear offset reads zero", 64'(m), 64'd0);
        wr(5'h04, 32'hFFFF_FFFF);

        // R3: register map and unaligned write ignored
        wr(5'h10, 32'hFFFF_1234);
        rd(5'h10, m); check("R3", "count word layout", 64'(m), 64'h000F_1234);
        wr(5'h11, 32'h0000_5555);
        rd(5'h10, m); check("R3", "unaligned write ignored", 64'(m), 64'h000F_1234);
        wr(5'h14, 32'hCAFE_0000);
        rd(5'h14, m); check("R3", "start1 register", 64'(m), 64'hCAFE_0000);
        wr(5'h10, 32'd0); wr(5'h14, 32'd0);

        // directed: each width and direction
        run_case(1'b0, 2'd2, 3, 2, 32'h0000_0100, 32'h0000_0200, 4'h0, 4'h0, 4'h3, 32'h1000_0040, 1'b1);
        run_case(1'b1, 2'd1, 2, 3, 32'h0000_0302, 32'h0001_0000, 4'h5, 4'hA, 4'h0, 32'h2000_0010, 1'b0);
        run_case(1'b0, 2'd0, 4, 1, 32'h0000_0007, 32'h0000_0FFF, 4'h1, 4'h2, 4'hF, 32'h3000_0000, 1'b1);
        run_case(1'b1, 2'd3, 1, 1, 32'h0000_0400, 32'h0000_0500, 4'h0, 4'h0, 4'h0, 32'h0, 1'b1);

        // R8: run with nothing enabled stays armed and idle
        wr(5'h00, RUN);
        repeat (4) @(negedge clk);
        rd(5'h00, m); check("R8", "stopped low with no buffer enabled", 64'(m & STP), 64'd0);
        no_req_window("R8", 20);
        stop_and_clean("R9");

        // R7/R8: zero-count buffer, then wait for buffer 1 enable
        wr(5'h08, 32'h0000_0080);
        wr(5'h0C, 32'h0000_0600);
        wr(5'h10, 32'd0);
        wr(5'h14, 32'h0000_0700);
        wr(5'h18, 32'd2);
        wr(5'h00, (32'd2 << 9) | EN0 | IE);
        wr(5'h00, RUN);
        wait_ctrl(DN0, ok);
        rd(5'h00, m);
        check("R7", "zero count completes and switches", 64'(m & 32'h7F), 64'(DN0 | ACT | RUN));
        check("R7", "no transfer for zero count", 64'(pcnt + mcnt), 64'd0);
        check("R10", "irq after first done", 64'(irq), 64'd1);
        no_req_window("R8", 20);
        wr(5'h00, EN1);
        wait_ctrl(DN1, ok);
        check("R8", "resumed after enable", 64'(pcnt), 64'd2);
        check("R5", "resumed buffer address", 64'(plog_data[1]), 64'(memval(36'h0_0000_0704)));
        rd(5'h00, m);
        check("R7", "active flag back to buffer 0", 64'(m & 32'h1F), 64'(DN0 | DN1));
        stop_and_clean("R9");

        // R9/R6: stop in the middle of a long buffer
        wr(5'h08, 32'h0000_00C0);
        wr(5'h0C, 32'h0000_1000);
        wr(5'h10, 32'd40);
        wr(5'h00, (32'd2 << 9) | EN0);
        wr(5'h00, RUN);
        for (int i = 0; i < 2000 && pcnt < 5; i++) @(negedge clk);
        wr(5'h04, RUN);
        wait_ctrl(STP, ok);
        check("R9", "stopped after run cleared mid-buffer", 64'(ok), 64'd1);
        n = pcnt;
        rd(5'h10, m); check("R6", "live residue matches transfers", 64'(m), 64'(40 - n));
        rd(5'h0C, m); check("R5", "address matches transfers", 64'(m), 64'(32'h1000 + 32'(4 * n)));
        no_req_window("R9", 20);
        check("R9", "no transfers once stopped", 64'(pcnt), 64'(n));
        wr(5'h04, 32'hFFFF_FFFF);
        mcnt = 0; pcnt = 0;

        // random rounds
        for (int r = 0; r < 8; r++) begin
            run_case(1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
                     $urandom_range(1, 6), $urandom_range(1, 6),
                     32'($urandom_range(0, 32'h00FF_FFFF)), 32'($urandom_range(0, 32'h00FF_FFFF)),
                     4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)),
                     4'($urandom_range(0, 15)), $urandom, 1'($urandom_range(0, 1)));
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (finished == 0) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule